// File: doc/BRIEF.md
# Two-Class Packet Priority Classifier and Queue Scheduler

This block sits between an Ethernet receive port and a shared transmit path. Each incoming IPv4 packet arrives as a fixed-size descriptor token. Alongside the token come the packet's IPv4 address, its ToS byte, a flag saying whether it is UDP, and its UDP port number. The block compares those fields against a small table of rules written by the host. A packet that matches any rule is tagged high priority. Every other packet is tagged low.

Tagged descriptors go into one of two FIFO queues. The output always serves the high queue while it holds anything, and the low queue only when the high queue is empty. Classification only applies to traffic from ports where prioritising is wanted. The source marks that with a per-packet enable, and packets without it always go low. When the queue a descriptor needs is full, the input is held off through a ready signal, so nothing is ever dropped.

Top module: `prio_classq`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and every rule is cleared, so no rule can match.
- R2: Each rule has a 3-bit field-select `use` (bit 0 = IPv4 address, bit 1 = ToS byte, bit 2 = UDP port). A packet matches a rule when every selected field equals the rule's value. A rule whose `use` is 000 never matches.
- R3: A rule that selects the UDP port matches only packets with `in_udp` = 1. Non-UDP packets never match it, whatever port value they carry.
- R4: A packet is high priority exactly when it matches at least one rule and `in_cls_en` = 1. With `in_cls_en` = 0 it is always low priority.
- R5: Classification takes one registered cycle. A descriptor accepted at clock edge k enters its queue at edge k+1 if that queue has room, and can be on the output from then on.
- R6: Whenever the high queue holds a descriptor, the output presents the head of the high queue with `out_high` = 1. The low queue is served only when the high queue is empty. `out_valid` stays 1 until a transfer with `out_ready` = 1.
- R7: Descriptors of the same class leave in the order they were accepted, and no descriptor is lost or duplicated.
- R8: While the classified descriptor waiting to enter a queue finds that queue full, `in_ready` is 0 and the waiting descriptor is held. Neither queue ever overflows.
- R9: A rule write (`cfg_we` = 1) takes effect for packets accepted from the next clock edge onwards, and replaces the rule at `cfg_idx` entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Rule write strobe |
| cfg_idx | input | $clog2(NRULE) | Rule index to write |
| cfg_addr | input | 32 | Rule IPv4 address |
| cfg_tos | input | 8 | Rule ToS byte |
| cfg_port | input | 16 | Rule UDP port |
| cfg_use | input | 3 | Field select: bit 0 address, bit 1 ToS, bit 2 UDP port |
| in_valid | input | 1 | Input descriptor valid |
| in_ready | output | 1 | Input descriptor accepted when valid and ready |
| in_desc | input | DW | Descriptor token |
| in_addr | input | 32 | Packet IPv4 address |
| in_tos | input | 8 | Packet ToS byte |
| in_udp | input | 1 | Packet is UDP |
| in_port | input | 16 | Packet UDP port |
| in_cls_en | input | 1 | Packet came from a port where classification applies |
| out_valid | output | 1 | Output descriptor valid |
| out_ready | input | 1 | Downstream takes the output descriptor |
| out_desc | output | DW | Output descriptor |
| out_high | output | 1 | Output descriptor comes from the high queue |

## Verification
The bench targets the following corner cases:
- A rule with no fields selected. A design that treated an empty field select as "match everything" would promote all traffic.
- A non-UDP packet whose port value happens to equal a port-selecting rule. A design that ignored the UDP flag would promote it wrongly.
- A full low queue with a further descriptor in the classification stage. Dropping that descriptor, or overwriting it, shows up as a missing or repeated token in the output order.
- High descriptors arriving behind pending low ones. A design without strict priority would emit them out of turn.
- A rule rewritten between packets. A design that kept stale state would misclassify the packets that follow.

// File: rtl/prio_classq_pkg.sv
// Shared types for the two-class priority classifier.
// Assumes IPv4 addressing and 16-bit UDP ports; field-select bit positions are fixed.
package prio_classq_pkg;
    localparam int ADDR_W = 32;
    localparam int TOS_W  = 8;
    localparam int PORT_W = 16;
    localparam int USE_W  = 3;

    localparam int F_ADDR = 0;
    localparam int F_TOS  = 1;
    localparam int F_PORT = 2;

    localparam int Q_LO = 0;
    localparam int Q_HI = 1;
    localparam int NQ   = 2;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [TOS_W-1:0]  tos;
        logic [PORT_W-1:0] port;
        logic [USE_W-1:0]  use_f;
    } rule_t;
endpackage

// File: rtl/prio_rule_table.sv
// Rule storage and match logic: NRULE registered rules, each compared in
// parallel against the current packet fields; hit is the OR of all matches.
// Assumes writes and lookups share one clock; a write is seen from the next cycle.
module prio_rule_table
    import prio_classq_pkg::*;
#(
    parameter int NRULE = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(NRULE)-1:0] wr_idx,
    input  rule_t                    wr_rule,
    input  logic [ADDR_W-1:0]        pkt_addr,
    input  logic [TOS_W-1:0]         pkt_tos,
    input  logic                     pkt_udp,
    input  logic [PORT_W-1:0]        pkt_port,
    output logic                     hit
);
    localparam int IW = $clog2(NRULE);

    logic [NRULE-1:0] match;

    for (genvar i = 0; i < NRULE; i++) begin : g_rule
        rule_t r;
        logic  ok_addr, ok_tos, ok_port;

        // Hold one rule; cleared on reset so it cannot match.
        always_ff @(posedge clk) begin
            if (!rst_n)
                r <= '0;
            else if (wr_en && wr_idx == IW'(i))
                r <= wr_rule;
        end

        // Compare each selected field; an unselected field always passes.
        always_comb begin
            ok_addr  = !r.use_f[F_ADDR] || (r.addr == pkt_addr);
            ok_tos   = !r.use_f[F_TOS]  || (r.tos  == pkt_tos);
            ok_port  = !r.use_f[F_PORT] || (pkt_udp && (r.port == pkt_port));
            match[i] = (r.use_f != '0) && ok_addr && ok_tos && ok_port;
        end

        // R3: a port-selecting rule only fires on UDP packets.
        p_port_needs_udp_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (match[i] && r.use_f[F_PORT]) |-> pkt_udp);
    end

    assign hit = |match;
endmodule

// File: rtl/prio_fifo.sv
// Descriptor FIFO of DEPTH entries with full and empty flags.
// Assumes the caller never pushes when full nor pops when empty;
// flags come from a registered count, so a pop does not free space in the same cycle.
module prio_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic          full,
    output logic          empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Store the pushed descriptor at the write pointer.
    always_ff @(posedge clk) begin
        if (push)
            mem[wp] <= din;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= nxt(wp);
            if (pop)  rp <= nxt(rp);
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end

    assign dout  = mem[rp];
    assign full  = (cnt == CW'(DEPTH));
    assign empty = (cnt == '0);

    // R8: nothing is written into a full queue.
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R7: nothing is read from an empty queue.
    p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/prio_classq.sv
// Two-class priority classifier and strict-priority queue scheduler.
// Classifies each accepted descriptor in one registered stage, files it into a
// high or low FIFO and always serves the high FIFO first.
// Assumes the input follows valid/ready: fields stay stable while in_valid waits.
module prio_classq
    import prio_classq_pkg::*;
#(
    parameter int NRULE = 4,
    parameter int DEPTH = 4,
    parameter int DW    = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [$clog2(NRULE)-1:0] cfg_idx,
    input  logic [31:0]              cfg_addr,
    input  logic [7:0]               cfg_tos,
    input  logic [15:0]              cfg_port,
    input  logic [2:0]               cfg_use,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [DW-1:0]            in_desc,
    input  logic [31:0]              in_addr,
    input  logic [7:0]               in_tos,
    input  logic                     in_udp,
    input  logic [15:0]              in_port,
    input  logic                     in_cls_en,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [DW-1:0]            out_desc,
    output logic                     out_high
);
    rule_t   wr_rule;
    logic    hit, pkt_hi, accept;
    logic    stg_vld, stg_hi, stg_push;
    logic [DW-1:0] stg_desc;

    logic [NQ-1:0] q_push, q_pop, q_full, q_empty;
    logic [DW-1:0] q_dout [NQ];

    // Pack the configuration port into one rule word.
    always_comb begin
        wr_rule.addr  = cfg_addr;
        wr_rule.tos   = cfg_tos;
        wr_rule.port  = cfg_port;
        wr_rule.use_f = cfg_use;
    end

    prio_rule_table #(.NRULE(NRULE)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_idx   (cfg_idx),
        .wr_rule  (wr_rule),
        .pkt_addr (in_addr),
        .pkt_tos  (in_tos),
        .pkt_udp  (in_udp),
        .pkt_port (in_port),
        .hit      (hit)
    );

    assign pkt_hi   = hit && in_cls_en;
    assign stg_push = |q_push;
    assign in_ready = !stg_vld || stg_push;
    assign accept   = in_valid && in_ready;

    // Classification stage: capture the descriptor with its class, release on push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_vld  <= 1'b0;
            stg_hi   <= 1'b0;
            stg_desc <= '0;
        end else if (accept) begin
            stg_vld  <= 1'b1;
            stg_hi   <= pkt_hi;
            stg_desc <= in_desc;
        end else if (stg_push) begin
            stg_vld  <= 1'b0;
        end
    end

    for (genvar c = 0; c < NQ; c++) begin : g_q
        // Push into the queue named by the stage; pop high first, low only when high is empty.
        assign q_push[c] = stg_vld && (stg_hi == (c == Q_HI)) && !q_full[c];
        assign q_pop[c]  = out_ready && !q_empty[c] && ((c == Q_HI) || q_empty[Q_HI]);

        prio_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (q_push[c]),
            .din   (stg_desc),
            .pop   (q_pop[c]),
            .dout  (q_dout[c]),
            .full  (q_full[c]),
            .empty (q_empty[c])
        );
    end

    assign out_valid = !(&q_empty);
    assign out_high  = !q_empty[Q_HI];
    assign out_desc  = out_high ? q_dout[Q_HI] : q_dout[Q_LO];

    // R8: a stalled stage keeps its descriptor unchanged.
    p_stage_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stg_vld && !stg_push) |=> (stg_vld && $stable(stg_desc) && $stable(stg_hi)));
    // R4: packets from ports without classification are always low.
    p_low_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !in_cls_en) |=> !stg_hi);
    // R6: an offered descriptor is not withdrawn before it is taken.
    p_valid_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid);
    // R6: a waiting high descriptor keeps the output on the high queue.
    p_hi_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_high && !out_ready) |=> out_high);
endmodule

// File: tb/prio_classq_test.sv
`timescale 1ns/1ps
module prio_classq_test;
    localparam int NRULE = 4;
    localparam int DEPTH = 4;
    localparam int DW    = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_idx = '0;
    logic [31:0] cfg_addr = '0;
    logic [7:0] cfg_tos = '0;
    logic [15:0] cfg_port = '0;
    logic [2:0] cfg_use = '0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [DW-1:0] in_desc = '0;
    logic [31:0] in_addr = '0;
    logic [7:0] in_tos = '0;
    logic in_udp = 1'b0;
    logic [15:0] in_port = '0;
    logic in_cls_en = 1'b0;
    logic out_valid;
    logic out_ready = 1'b0;
    logic [DW-1:0] out_desc;
    logic out_high;

    always #2 clk = ~clk;

    prio_classq #(.NRULE(NRULE), .DEPTH(DEPTH), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_addr(cfg_addr), .cfg_tos(cfg_tos),
        .cfg_port(cfg_port), .cfg_use(cfg_use),
        .in_valid(in_valid), .in_ready(in_ready), .in_desc(in_desc),
        .in_addr(in_addr), .in_tos(in_tos), .in_udp(in_udp), .in_port(in_port),
        .in_cls_en(in_cls_en),
        .out_valid(out_valid), .out_ready(out_ready), .out_desc(out_desc),
        .out_high(out_high)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    string cur_tag = "R2";
    logic [DW-1:0] next_desc = 16'h0100;

    // Behavioural reference: rule table, one-entry stage, two queues.
    logic [31:0] t_addr [NRULE];
    logic [7:0]  t_tos  [NRULE];
    logic [15:0] t_port [NRULE];
    logic [2:0]  t_use  [NRULE];
    logic [DW-1:0] mq_hi [$];
    logic [DW-1:0] mq_lo [$];
    bit m_sv, m_shi;
    logic [DW-1:0] m_sdesc;

    function automatic bit ref_class(logic [31:0] a, logic [7:0] t, logic u,
                                     logic [15:0] p, logic en);
        bit h = 1'b0;
        for (int i = 0; i < NRULE; i++) begin
            if (t_use[i] != 3'b000
                && (!t_use[i][0] || t_addr[i] == a)
                && (!t_use[i][1] || t_tos[i] == t)
                && (!t_use[i][2] || (u && t_port[i] == p)))
                h = 1'b1;
        end
        return h && en;
    endfunction

    function automatic bit exp_ready();
        int sz = m_shi ? mq_hi.size() : mq_lo.size();
        return !m_sv || sz < DEPTH;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mq_hi.delete(); mq_lo.delete();
            m_sv = 1'b0; m_shi = 1'b0; m_sdesc = '0;
            for (int i = 0; i < NRULE; i++) begin
                t_addr[i] = '0; t_tos[i] = '0; t_port[i] = '0; t_use[i] = '0;
            end
        end else begin
            bit rdy, cls, pushok;
            rdy = exp_ready();
            cls = ref_class(in_addr, in_tos, in_udp, in_port, in_cls_en);
            pushok = m_sv && ((m_shi ? mq_hi.size() : mq_lo.size()) < DEPTH);
            if (out_ready) begin
                if (mq_hi.size() > 0) void'(mq_hi.pop_front());
                else if (mq_lo.size() > 0) void'(mq_lo.pop_front());
            end
            if (pushok) begin
                if (m_shi) mq_hi.push_back(m_sdesc);
                else mq_lo.push_back(m_sdesc);
            end
            if (in_valid && rdy) begin
                m_sv = 1'b1; m_shi = cls; m_sdesc = in_desc;
            end else if (pushok) begin
                m_sv = 1'b0;
            end
            if (cfg_we) begin
                t_addr[cfg_idx] = cfg_addr; t_tos[cfg_idx] = cfg_tos;
                t_port[cfg_idx] = cfg_port; t_use[cfg_idx] = cfg_use;
            end
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit ev, eh;
            logic [DW-1:0] ed;
            ev = (mq_hi.size() + mq_lo.size()) > 0;
            eh = mq_hi.size() > 0;
            ed = eh ? mq_hi[0] : (ev ? mq_lo[0] : '0);
            checks++;
            if (in_ready !== exp_ready()) begin
                errors++;
                $display("FAIL R8 in_ready got %0b exp %0b", in_ready, exp_ready());
            end
            checks++;
            if (out_valid !== ev) begin
                errors++;
                $display("FAIL R5 out_valid got %0b exp %0b", out_valid, ev);
            end
            if (ev) begin
                checks++;
                if (out_high !== eh) begin
                    errors++;
                    $display("FAIL %s out_high got %0b exp %0b", cur_tag, out_high, eh);
                end
                checks++;
                if (out_desc !== ed) begin
                    errors++;
                    $display("FAIL R6/R7 out_desc got %h exp %h", out_desc, ed);
                end
            end
        end
    end

    task automatic prog(input int idx, input logic [31:0] a, input logic [7:0] t,
                        input logic [15:0] p, input logic [2:0] u);
        cfg_we = 1'b1; cfg_idx = idx[1:0]; cfg_addr = a; cfg_tos = t;
        cfg_port = p; cfg_use = u;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(input logic [31:0] a, input logic [7:0] t, input logic u,
                        input logic [15:0] p, input logic en);
        bit rdy_now;
        in_valid = 1'b1; in_addr = a; in_tos = t; in_udp = u; in_port = p;
        in_cls_en = en; in_desc = next_desc;
        next_desc++;
        do begin
            rdy_now = in_ready;
            @(negedge clk);
        end while (!rdy_now);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    localparam logic [31:0] A_VOIP = 32'h0A00_0005;
    localparam logic [31:0] A_TOS  = 32'hC0A8_0102;
    localparam logic [31:0] A_ALL  = 32'hAC10_0009;
    localparam logic [31:0] A_OFF  = 32'h0A0A_0A0A;

    initial begin
        int cyc = 0;
        while (!finished) begin
            @(posedge clk);
            cyc++;
            if (cyc > 50000) begin
                errors++;
                $display("FAIL watchdog expired");
                finished = 1'b1;
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        idle(3);
        // R1: reset state
        checks++;
        if (in_ready !== 1'b1 || out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset in_ready/out_valid got %0b/%0b exp 1/0", in_ready, out_valid);
        end
        rst_n = 1'b1;
        idle(1);
        // R1: cleared rules do not match
        cur_tag = "R1";
        out_ready = 1'b1;
        send(32'h0, 8'h0, 1'b1, 16'h0, 1'b1);
        idle(3);

        // R2: field selects (bit0 addr, bit1 ToS, bit2 UDP port)
        cur_tag = "R2";
        prog(0, A_VOIP, 8'h00, 16'd5060, 3'b101);
        prog(1, A_TOS, 8'hB8, 16'd0, 3'b011);
        prog(2, A_ALL, 8'h28, 16'd4000, 3'b111);
        prog(3, A_OFF, 8'h00, 16'd0, 3'b000);
        send(A_VOIP, 8'h11, 1'b1, 16'd5060, 1'b1);
        send(A_VOIP, 8'h11, 1'b1, 16'd5061, 1'b1);
        send(A_TOS, 8'hB8, 1'b0, 16'd9, 1'b1);
        send(A_TOS, 8'hB9, 1'b0, 16'd9, 1'b1);
        send(A_ALL, 8'h28, 1'b1, 16'd4000, 1'b1);
        send(A_ALL, 8'h29, 1'b1, 16'd4000, 1'b1);
        send(A_OFF, 8'h00, 1'b0, 16'd0, 1'b1);
        idle(4);

        // R3: non-UDP packets never match a port rule
        cur_tag = "R3";
        send(A_VOIP, 8'h00, 1'b0, 16'd5060, 1'b1);
        send(A_ALL, 8'h28, 1'b0, 16'd4000, 1'b1);
        idle(4);

        // R4: classification disabled for this port
        cur_tag = "R4";
        send(A_VOIP, 8'h00, 1'b1, 16'd5060, 1'b0);
        send(A_TOS, 8'hB8, 1'b0, 16'd0, 1'b0);
        idle(4);

        // R6: strict priority when both queues wait
        cur_tag = "R6";
        out_ready = 1'b0;
        send(A_OFF, 8'h0, 1'b0, 16'd0, 1'b1);
        send(A_OFF, 8'h0, 1'b0, 16'd0, 1'b1);
        send(A_OFF, 8'h0, 1'b0, 16'd0, 1'b1);
        send(A_VOIP, 8'h0, 1'b1, 16'd5060, 1'b1);
        send(A_TOS, 8'hB8, 1'b0, 16'd0, 1'b1);
        idle(3);
        out_ready = 1'b1;
        idle(8);

        // R8: back-pressure with full low queue, nothing lost
        cur_tag = "R8";
        out_ready = 1'b0;
        fork
            begin
                for (int k = 0; k < 8; k++) send(A_OFF, 8'h0, 1'b0, 16'd0, 1'b1);
                send(A_VOIP, 8'h0, 1'b1, 16'd5060, 1'b1);
            end
            begin
                idle(20);
                out_ready = 1'b1;
            end
        join
        idle(12);

        // R9: rule rewrite takes effect for following packets
        cur_tag = "R9";
        send(A_OFF, 8'h0, 1'b0, 16'd0, 1'b1);
        prog(3, A_OFF, 8'h00, 16'd0, 3'b001);
        send(A_OFF, 8'h0, 1'b0, 16'd0, 1'b1);
        prog(0, A_VOIP, 8'h00, 16'd5060, 3'b000);
        send(A_VOIP, 8'h0, 1'b1, 16'd5060, 1'b1);
        idle(4);

        // R5/R7: mixed traffic with a throttled output
        cur_tag = "R7";
        fork
            begin
                logic [7:0] s = 8'h5A;
                for (int k = 0; k < 80; k++) begin
                    s = {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
                    case (s[1:0])
                        2'd0: send(A_OFF, 8'h0, s[2], 16'd7, s[3]);
                        2'd1: send(A_TOS, s[4] ? 8'hB8 : 8'h00, s[2], 16'd1, s[3] | s[5]);
                        2'd2: send(A_ALL, 8'h28, s[2], 16'd4000, 1'b1);
                        default: send(A_VOIP, 8'h0, 1'b0, 16'd5060, 1'b1);
                    endcase
                    if (s[6]) idle(1);
                end
            end
            begin
                for (int k = 0; k < 400; k++) begin
                    out_ready = (k % 5 != 0) && (k % 7 != 3);
                    @(negedge clk);
                end
                out_ready = 1'b1;
            end
        join
        idle(20);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule